// File: doc/BRIEF.md
# PHY PLL Configuration Write Sequencer

This block turns a set of already computed PLL settings into the ordered list of test-port register writes that a D-PHY needs before its PLL can lock at a chosen rate. On a start pulse it samples the input divider `n`, the loop divider `m`, the VCO band code, the post-divider and the target frequency. It then issues thirteen writes on a code/data port with a valid/ready handshake. The target frequency is the PLL output in MHz, which equals half the lane rate in Mbps.

Most written values are fixed. Four of them depend on the settings. The VCO band is written with its override bit set. The input divider is written on its own. The 10-bit loop divider is split into a low part and a high part, sent as two writes to the same code, with a flag bit on the high part. The proportional charge-pump setting is chosen by comparing target frequency × post-divider against a threshold. One cycle after the last write is accepted, the block pulses `done_o`. The caller may then turn the PLL on.

Top module: `pll_cfg_sequencer`

## Requirements
- R1: After reset, `wr_valid_o` and `done_o` are low.
- R2: A start pulse while idle samples all setting inputs and begins the sequence. Write 1 is code 0x12 with data 0x40 | band, where band is the 6-bit VCO band code.
- R3: Write 2 is code 0x17 with data equal to n in bits 3:0 and zero above.
- R4: Writes 3 and 4 both use code 0x18. Write 3 carries m[4:0] in bits 4:0. Write 4 carries m[9:5] in bits 4:0 with bit 7 set.
- R5: Write 5 is code 0x19 with data 0x30, which sets the n and m override enables in bits 4 and 5.
- R6: Write 6 is code 0x0E. Its data is 0x0C when target × post-divider is strictly greater than 1150, and 0x0B otherwise. 1150 itself gives 0x0B.
- R7: Writes 7, 8 and 9 are, in order: code 0x0F with data 0x00, code 0x13 with data 0x10, and code 0x1C with data 0x10.
- R8: Writes 10 to 13 are, in order: code 0x14 with data 0x02, code 0x15 with data 0x60, code 0x16 with data 0x03, and code 0x1D with data 0x02.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, valid, code and data hold unchanged into the next cycle.
- R10: `done_o` is high for exactly one cycle. That cycle directly follows the clock edge on which write 13 is accepted, and `wr_valid_o` is low during it.
- R11: Start pulses and changes to the setting inputs after the sequence has begun have no effect until the done cycle has passed. This includes a start pulse during the done cycle, which does not launch a new sequence.
- R12: With `wr_ready_i` held high, the thirteen writes are accepted on thirteen consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| div_n_i | input | 4 | PLL input divider setting n |
| div_m_i | input | 10 | PLL loop divider setting m |
| vco_band_i | input | 6 | VCO band code |
| post_div_i | input | 4 | Output post-divider |
| tgt_mhz_i | input | 12 | Target PLL frequency in MHz (half the lane rate) |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted when high together with valid |
| wr_code_o | output | 8 | Test register code |
| wr_data_o | output | 8 | Test register data |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The sequence is run with three stimulus patterns:
- ready held high, which checks back-to-back timing;
- random ready stalls, which check that each write is held stable and that no write is skipped or repeated;
- start pulses and changed setting inputs injected mid-run and in the done cycle, which separate sampling at start from live use of the inputs.

Values of n, m and band at both ends of their ranges show whether bits are misplaced in the split loop-divider writes. Target and post-divider pairs whose product is 1150, 1151 and 1200 fix which side of the threshold the charge-pump setting falls on. A case with a post-divider above 1 shows whether the post-divider is actually applied.

// File: rtl/pll_cfg_pkg.sv
// Package pll_cfg_pkg
// Shared widths, the sequencer state type and the test register codes.
// Assumes an 8-bit test code and an 8-bit test data path on the PHY side.
package pll_cfg_pkg;

    localparam int CODE_W     = 8;
    localparam int DATA_W     = 8;
    localparam int NUM_WRITES = 13;
    localparam int STEP_W     = $clog2(NUM_WRITES);
    localparam int LAST_STEP  = NUM_WRITES - 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;

    // Test register codes; the PHY decodes these values.
    localparam logic [CODE_W-1:0] C_VCO_BAND   = 8'h12;
    localparam logic [CODE_W-1:0] C_IN_DIV     = 8'h17;
    localparam logic [CODE_W-1:0] C_LOOP_DIV   = 8'h18;
    localparam logic [CODE_W-1:0] C_DIV_OVR    = 8'h19;
    localparam logic [CODE_W-1:0] C_CP_PROP    = 8'h0E;
    localparam logic [CODE_W-1:0] C_CP_INT     = 8'h0F;
    localparam logic [CODE_W-1:0] C_GMP        = 8'h13;
    localparam logic [CODE_W-1:0] C_CP_BIAS    = 8'h1C;
    localparam logic [CODE_W-1:0] C_PHASE_TH   = 8'h14;
    localparam logic [CODE_W-1:0] C_LOCK_FLT   = 8'h15;
    localparam logic [CODE_W-1:0] C_UNLOCK_FLT = 8'h16;
    localparam logic [CODE_W-1:0] C_LOCK_SEL   = 8'h1D;

    // Flag bits inside data fields.
    localparam logic [DATA_W-1:0] F_BAND_OVR = 8'h40;
    localparam logic [DATA_W-1:0] F_M_HIGH   = 8'h80;
    localparam logic [DATA_W-1:0] F_NM_OVR   = 8'h30;

    // Fixed data values.
    localparam logic [DATA_W-1:0] D_CP_FAST    = 8'h0C;
    localparam logic [DATA_W-1:0] D_CP_SLOW    = 8'h0B;
    localparam logic [DATA_W-1:0] D_CP_INT     = 8'h00;
    localparam logic [DATA_W-1:0] D_GMP        = 8'h10;
    localparam logic [DATA_W-1:0] D_CP_BIAS    = 8'h10;
    localparam logic [DATA_W-1:0] D_PHASE_TH   = 8'h02;
    localparam logic [DATA_W-1:0] D_LOCK_FLT   = 8'h60;
    localparam logic [DATA_W-1:0] D_UNLOCK_FLT = 8'h03;
    localparam logic [DATA_W-1:0] D_LOCK_SEL   = 8'h02;

endpackage

// File: rtl/pll_cfg_capture.sv
// Module pll_cfg_capture
// Samples the PLL settings on a start that the controller accepts.
// It also registers the charge-pump range decision, so the write path
// only reads flops. Assumes the inputs are valid in the start cycle.
module pll_cfg_capture #(
    parameter int N_W       = 4,
    parameter int M_W       = 10,
    parameter int BAND_W    = 6,
    parameter int PDIV_W    = 4,
    parameter int TGT_W     = 12,
    parameter int CP_THRESH = 1150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic [N_W-1:0]    div_n_i,
    input  logic [M_W-1:0]    div_m_i,
    input  logic [BAND_W-1:0] vco_band_i,
    input  logic [PDIV_W-1:0] post_div_i,
    input  logic [TGT_W-1:0]  tgt_mhz_i,
    output logic [N_W-1:0]    n_q_o,
    output logic [M_W-1:0]    m_q_o,
    output logic [BAND_W-1:0] band_q_o,
    output logic              cp_fast_q_o
);

    localparam int PROD_W = TGT_W + PDIV_W;

    logic [PROD_W-1:0] vco_prod;
    logic              cp_fast;

    // Scale the target by the post-divider and compare it with the threshold.
    always_comb begin
        vco_prod = PROD_W'(tgt_mhz_i) * PROD_W'(post_div_i);
        cp_fast  = (vco_prod > PROD_W'(CP_THRESH));
    end

    // Hold the sampled settings for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q_o       <= '0;
            m_q_o       <= '0;
            band_q_o    <= '0;
            cp_fast_q_o <= 1'b0;
        end else if (cap_en_i) begin
            n_q_o       <= div_n_i;
            m_q_o       <= div_m_i;
            band_q_o    <= vco_band_i;
            cp_fast_q_o <= cp_fast;
        end
    end

endmodule

// File: rtl/pll_cfg_ctrl.sv
// Module pll_cfg_ctrl
// Sequencer state machine: idle, running through the write steps, and a
// single finish cycle that drives done. Accepts start only when idle and
// advances the step index on each valid/ready handshake.
module pll_cfg_ctrl
    import pll_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ready_i,
    output logic              cap_en_o,
    output logic              valid_o,
    output logic              done_o,
    output logic [STEP_W-1:0] step_o
);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [STEP_W-1:0] step_d;
    logic              last_step;

    // Decode the outputs from the current state.
    always_comb begin
        cap_en_o  = (state_q == ST_IDLE) && start_i;
        valid_o   = (state_q == ST_RUN);
        done_o    = (state_q == ST_FINISH);
        last_step = (step_o == STEP_W'(LAST_STEP));
    end

    // Next-state and step logic.
    always_comb begin
        state_d = state_q;
        step_d  = step_o;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_RUN;
                    step_d  = '0;
                end
            end
            ST_RUN: begin
                if (ready_i) begin
                    if (last_step) begin
                        state_d = ST_FINISH;
                    end else begin
                        step_d = step_o + 1'b1;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_o  <= '0;
        end else begin
            state_q <= state_d;
            step_o  <= step_d;
        end
    end

endmodule

// File: rtl/pll_cfg_packer.sv
// Module pll_cfg_packer
// Maps a step index and the sampled settings to the code/data pair of
// that write. Purely combinational. Assumes its inputs come from flops,
// so the outputs stay steady while a write is stalled.
module pll_cfg_packer
    import pll_cfg_pkg::*;
#(
    parameter int N_W    = 4,
    parameter int M_W    = 10,
    parameter int BAND_W = 6,
    parameter int M_LO_W = 5
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [N_W-1:0]    n_i,
    input  logic [M_W-1:0]    m_i,
    input  logic [BAND_W-1:0] band_i,
    input  logic              cp_fast_i,
    output logic [CODE_W-1:0] code_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int M_HI_W = M_W - M_LO_W;

    logic [DATA_W-1:0] m_lo;
    logic [DATA_W-1:0] m_hi;

    // Split the loop divider into its two write fields.
    always_comb begin
        m_lo = DATA_W'(m_i[M_LO_W-1:0]);
        m_hi = DATA_W'(m_i[M_W-1:M_LO_W]);
    end

    // Select the code and data for the current step.
    always_comb begin
        code_o = C_LOCK_SEL;
        data_o = D_LOCK_SEL;
        case (step_i)
            4'd0:  begin code_o = C_VCO_BAND;   data_o = DATA_W'(band_i) | F_BAND_OVR; end
            4'd1:  begin code_o = C_IN_DIV;     data_o = DATA_W'(n_i);                 end
            4'd2:  begin code_o = C_LOOP_DIV;   data_o = m_lo;                         end
            4'd3:  begin code_o = C_LOOP_DIV;   data_o = m_hi | F_M_HIGH;              end
            4'd4:  begin code_o = C_DIV_OVR;    data_o = F_NM_OVR;                     end
            4'd5:  begin code_o = C_CP_PROP;    data_o = cp_fast_i ? D_CP_FAST : D_CP_SLOW; end
            4'd6:  begin code_o = C_CP_INT;     data_o = D_CP_INT;                     end
            4'd7:  begin code_o = C_GMP;        data_o = D_GMP;                        end
            4'd8:  begin code_o = C_CP_BIAS;    data_o = D_CP_BIAS;                    end
            4'd9:  begin code_o = C_PHASE_TH;   data_o = D_PHASE_TH;                   end
            4'd10: begin code_o = C_LOCK_FLT;   data_o = D_LOCK_FLT;                   end
            4'd11: begin code_o = C_UNLOCK_FLT; data_o = D_UNLOCK_FLT;                 end
            default: begin code_o = C_LOCK_SEL; data_o = D_LOCK_SEL;                   end
        endcase
    end

    // The high field must fit below the flag bit.
    if (M_HI_W > 7) begin : g_bad_width
        initial $error("loop divider high field too wide");
    end

endmodule

// File: rtl/pll_cfg_sequencer.sv
// Module pll_cfg_sequencer (top)
// Writes the PLL settings into the PHY test registers as a fixed series
// of thirteen code/data writes over a valid/ready port, then pulses done.
// Assumes the settings are valid in the cycle that start is high.
module pll_cfg_sequencer
    import pll_cfg_pkg::*;
#(
    parameter int N_W       = 4,
    parameter int M_W       = 10,
    parameter int BAND_W    = 6,
    parameter int PDIV_W    = 4,
    parameter int TGT_W     = 12,
    parameter int CP_THRESH = 1150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [N_W-1:0]    div_n_i,
    input  logic [M_W-1:0]    div_m_i,
    input  logic [BAND_W-1:0] vco_band_i,
    input  logic [PDIV_W-1:0] post_div_i,
    input  logic [TGT_W-1:0]  tgt_mhz_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [CODE_W-1:0] wr_code_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o
);

    logic              cap_en;
    logic [STEP_W-1:0] step;
    logic [N_W-1:0]    n_q;
    logic [M_W-1:0]    m_q;
    logic [BAND_W-1:0] band_q;
    logic              cp_fast_q;

    pll_cfg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .ready_i  (wr_ready_i),
        .cap_en_o (cap_en),
        .valid_o  (wr_valid_o),
        .done_o   (done_o),
        .step_o   (step)
    );

    pll_cfg_capture #(
        .N_W(N_W), .M_W(M_W), .BAND_W(BAND_W),
        .PDIV_W(PDIV_W), .TGT_W(TGT_W), .CP_THRESH(CP_THRESH)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en_i    (cap_en),
        .div_n_i     (div_n_i),
        .div_m_i     (div_m_i),
        .vco_band_i  (vco_band_i),
        .post_div_i  (post_div_i),
        .tgt_mhz_i   (tgt_mhz_i),
        .n_q_o       (n_q),
        .m_q_o       (m_q),
        .band_q_o    (band_q),
        .cp_fast_q_o (cp_fast_q)
    );

    pll_cfg_packer #(
        .N_W(N_W), .M_W(M_W), .BAND_W(BAND_W)
    ) u_packer (
        .step_i    (step),
        .n_i       (n_q),
        .m_i       (m_q),
        .band_i    (band_q),
        .cp_fast_i (cp_fast_q),
        .code_o    (wr_code_o),
        .data_o    (wr_data_o)
    );

endmodule

// File: rtl/pll_cfg_sequencer_chk.sv
// Module pll_cfg_sequencer_chk
// Protocol and content checks on the write port, bound to the top module.
module pll_cfg_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid_o,
    input logic       wr_ready_i,
    input logic [7:0] wr_code_o,
    input logic [7:0] wr_data_o,
    input logic       done_o
);

    // R9: a stalled write keeps valid, code and data.
    assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_code_o) && $stable(wr_data_o)));

    // R10: done lasts one cycle.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: done follows acceptance of the lock selector write.
    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_valid_o && wr_ready_i && wr_code_o == 8'h1D));

    // R10: no write is offered in the done cycle.
    assert_no_valid_in_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_valid_o);

    // R2: each sequence opens with the VCO band write.
    assert_first_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid_o) |-> (wr_code_o == 8'h12 && wr_data_o[6]));

    // R5: the override write carries both enables.
    assert_ovr_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_code_o == 8'h19) |-> (wr_data_o == 8'h30));

    // R8: the lock filter write carries its fixed value.
    assert_lock_flt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_code_o == 8'h15) |-> (wr_data_o == 8'h60));

endmodule

bind pll_cfg_sequencer pll_cfg_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_code_o  (wr_code_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o)
);

// File: tb/test_pll_cfg_sequencer.sv
// Directed bench for pll_cfg_sequencer. Inputs change on the falling edge.
// Outputs are sampled on the falling edge.
module test_pll_cfg_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] div_n_i = '0;
    logic [9:0] div_m_i = '0;
    logic [5:0] vco_band_i = '0;
    logic [3:0] post_div_i = '0;
    logic [11:0] tgt_mhz_i = '0;
    logic       wr_valid_o;
    logic       wr_ready_i = 1'b0;
    logic [7:0] wr_code_o;
    logic [7:0] wr_data_o;
    logic       done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pll_cfg_sequencer i_pll_cfg_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .div_n_i(div_n_i), .div_m_i(div_m_i), .vco_band_i(vco_band_i),
        .post_div_i(post_div_i), .tgt_mhz_i(tgt_mhz_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
        .wr_code_o(wr_code_o), .wr_data_o(wr_data_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input int i);
        case (i)
            0: return 8'h12;  1: return 8'h17;  2: return 8'h18;  3: return 8'h18;
            4: return 8'h19;  5: return 8'h0E;  6: return 8'h0F;  7: return 8'h13;
            8: return 8'h1C;  9: return 8'h14; 10: return 8'h15; 11: return 8'h16;
            default: return 8'h1D;
        endcase
    endfunction

    function automatic logic [7:0] exp_data(input int i, input logic [5:0] band,
            input logic [3:0] n, input logic [9:0] m, input logic [3:0] pd, input logic [11:0] tgt);
        int prod;
        prod = int'(tgt) * int'(pd);
        case (i)
            0: return {2'b01, band};
            1: return {4'h0, n};
            2: return {3'b000, m[4:0]};
            3: return {3'b100, m[9:5]};
            4: return 8'h30;
            5: return (prod > 1150) ? 8'h0C : 8'h0B;
            6: return 8'h00;  7: return 8'h10;  8: return 8'h10;
            9: return 8'h02; 10: return 8'h60; 11: return 8'h03;
            default: return 8'h02;
        endcase
    endfunction

    function automatic string req_of(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5: return "R6";
            6, 7, 8: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Run one full sequence; stall selects random ready, poke injects start and input changes.
    task automatic run_seq(input logic [5:0] band, input logic [3:0] n, input logic [9:0] m,
            input logic [3:0] pd, input logic [11:0] tgt, input bit stall, input bit poke);
        int accepted = 0;
        int cycles = 0;
        bit was_stalled = 1'b0;
        logic [7:0] pcode = '0;
        logic [7:0] pdata = '0;
        @(negedge clk);
        vco_band_i = band; div_n_i = n; div_m_i = m; post_div_i = pd; tgt_mhz_i = tgt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (accepted < 13 && cycles < 2000) begin
            cycles++;
            if (poke && accepted == 5) begin
                start_i = 1'b1;
                vco_band_i = ~band; div_n_i = ~n; div_m_i = ~m; post_div_i = 4'd15; tgt_mhz_i = 12'd4000;
            end else begin
                start_i = 1'b0;
            end
            check("R2 valid during run", {15'd0, wr_valid_o}, 16'd1);
            if (was_stalled) begin
                check("R9 code held", {8'd0, wr_code_o}, {8'd0, pcode});
                check("R9 data held", {8'd0, wr_data_o}, {8'd0, pdata});
            end
            wr_ready_i = stall ? (($urandom % 3) != 0) : 1'b1;
            if (wr_ready_i) begin
                check({req_of(accepted), " code"}, {8'd0, wr_code_o}, {8'd0, exp_code(accepted)});
                check({req_of(accepted), " data"}, {8'd0, wr_data_o},
                      {8'd0, exp_data(accepted, band, n, m, pd, tgt)});
                accepted++;
                was_stalled = 1'b0;
            end else begin
                was_stalled = 1'b1;
                pcode = wr_code_o;
                pdata = wr_data_o;
            end
            @(negedge clk);
        end
        wr_ready_i = 1'b0;
        start_i = 1'b0;
        if (!stall) check("R12 back-to-back cycles", 16'(cycles), 16'd13);
        check("R10 done after last", {15'd0, done_o}, 16'd1);
        check("R10 no valid in done", {15'd0, wr_valid_o}, 16'd0);
        if (poke) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 done one cycle", {15'd0, done_o}, 16'd0);
        if (poke) check("R11 start in done cycle ignored", {15'd0, wr_valid_o}, 16'd0);
        @(negedge clk);
        check("R11 stays idle", {15'd0, wr_valid_o}, 16'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid after reset", {15'd0, wr_valid_o}, 16'd0);
        check("R1 done after reset", {15'd0, done_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle without start", {15'd0, wr_valid_o}, 16'd0);
    endtask

    task automatic t_back_to_back();
        run_seq(6'h09, 4'd1, 10'd100, 4'd1, 12'd600, 1'b0, 1'b0);   // R12, R6 low side
    endtask

    task automatic t_stalls_extremes();
        run_seq(6'h3F, 4'd15, 10'd623, 4'd1, 12'd1151, 1'b1, 1'b0); // R6 above threshold
        run_seq(6'h00, 4'd0, 10'd62, 4'd1, 12'd1150, 1'b1, 1'b0);   // R6 exactly at threshold
    endtask

    task automatic t_post_div();
        run_seq(6'h29, 4'd3, 10'd512, 4'd4, 12'd300, 1'b1, 1'b0);   // R6 product 1200
        run_seq(6'h1F, 4'd7, 10'd31, 4'd2, 12'd575, 1'b0, 1'b0);    // R6 product 1150
    endtask

    task automatic t_start_ignored();
        run_seq(6'h15, 4'd10, 10'd341, 4'd1, 12'd400, 1'b1, 1'b1);  // R11
    endtask

    initial begin
        t_reset();
        t_back_to_back();
        t_stalls_extremes();
        t_post_div();
        t_start_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule